// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and picks the one the core services next. It has seventeen sources in a fixed priority order. The highest is the start-up (reset) request and the lowest is the software break. The sources in between are six edge-sensitive external pins, a keypad wake-up port, seven timer and serial pulses, and one slot that is shared between a converter trigger pin and a conversion-done pulse. Each maskable source has a latched request bit and an enable bit, and a global disable flag gates all of them.

The core watches `irq_o` and answers with a one-cycle `ack_i`. In the following cycle the controller raises `push_o` so that the core saves its program counter and status. It also shows the winner's index and the addresses of its vector's low and high bytes, sets the disable flag and drops the accepted request. Software writes the enables, the edge polarities and a control word through a small write-only register port. The request bits can only be cleared from that port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the disable flag reads 1, `push_o` is low and the start-up request (index 0) is pending. The first acknowledge therefore takes index 0, with vector bytes at 0xFFFC and 0xFFFD.
- R2: Sources are numbered 0 to 16 and a lower index has higher priority. 0 start-up, 1 pin0, 2 pin1, 3 serial receive, 4 serial transmit, 5 timer X, 6 timer Y, 7 timer 2, 8 timer 3, 9 pin2, 10 pin3, 11 timer 1, 12 pin4, 13 pin5, 14 key port, 15 converter slot, 16 break. The low vector byte is at 0xFFFC minus twice the index, and the high byte is at low plus one.
- R3: A source with index 1 to 15 qualifies only when its request bit is 1, its enable bit is 1 and the disable flag is 0.
- R4: A pulse on `brk_i` latches request 16. That request qualifies regardless of any enable bit or the disable flag.
- R5: When `ack_i` is high while `irq_o` is high, the next cycle shows `push_o` high for one cycle, the winner on `src_o`, `vec_lo_o` and `vec_hi_o`, and the disable flag set. Only the winner's request is cleared and every other pending request stays latched. An acknowledge while `irq_o` is low produces no push.
- R6: Register port (`reg_we_i`, `reg_addr_i`). Address 0 loads the enables, with bit i belonging to source i for i from 1 to 15. At address 1, writing 0 to bit i (1 to 15) clears request i and writing 1 leaves it unchanged, so no request can be set this way. Address 2 holds the pin polarities, bit k for pin k, with 1 meaning rising and 0 meaning falling. Address 3 is control: bit0 enables serial mode, bit1 selects the converter source (1 conversion-done, 0 trigger pin), and bit2 writes the disable flag.
- R7: Each external pin passes through a two-stage synchronizer. A pin edge changed just after clock edge n sets its request at clock edge n+3.
- R8: A pin's request is set when the selected polarity applied to the synchronized level becomes active. Rewriting the polarity can therefore set a request by itself: switching to rising while the pin is high, or to falling while the pin is low, sets it.
- R9: Request 14 is set on a falling edge of the AND of those `key_port_i` bits whose `key_inmode_i` bit is 1. Bits with `key_inmode_i` at 0 are ignored.
- R10: Slot 15 is set by the conversion-done pulse `evt_i[7]` when control bit1 is 1. When bit1 is 0 it is set by a falling edge on the synchronized `adt_pin_i`, and `evt_i[7]` is ignored.
- R11: The serial pulses `evt_i[0]` (receive) and `evt_i[1]` (transmit) set requests 3 and 4 only while control bit0 is 1.
- R12: A request that is set by an event in the same cycle as a software clear or an acceptance clear of that request remains set.
- R13: The pulse inputs map as follows: `evt_i[2]` to 5, `evt_i[3]` to 6, `evt_i[4]` to 7, `evt_i[5]` to 8 and `evt_i[6]` to 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 6 | External edge pins 0..5 (asynchronous) |
| key_port_i | input | 8 | Keypad port levels (asynchronous) |
| key_inmode_i | input | 8 | 1 marks a port bit as input mode |
| adt_pin_i | input | 1 | Converter trigger pin (asynchronous) |
| evt_i | input | 8 | Internal one-cycle event pulses |
| brk_i | input | 1 | Software break request pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| ack_i | input | 1 | Core acknowledge |
| irq_o | output | 1 | A qualifying request is pending |
| push_o | output | 1 | Save context now (one cycle after accept) |
| src_o | output | 5 | Index of the accepted source |
| vec_lo_o | output | 16 | Address of the vector's low byte |
| vec_hi_o | output | 16 | Address of the vector's high byte |
| iflag_o | output | 1 | Global disable flag |

## Verification
The assertions check four things on every cycle. A push only follows an acknowledge of a pending request, and every such acknowledge produces a push. A push always leaves the disable flag set and reports vector addresses consistent with the reported index. While the flag is set, only the start-up or break source can be taken, and the first push after reset is the start-up one. The scenarios are needed to show the priority ranking among several pending sources, the polarity-change side effect, the synchronizer latency and the keypad AND. They are also needed for the serial and converter gating, for the inert writes of 1 to requests, and for event-versus-clear precedence, because each of these depends on a particular sequence of stimulus.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC  = 17;
  localparam int SRC_BRK  = 16;
  localparam int SRC_RX   = 3;
  localparam int SRC_TX   = 4;
  localparam int SRC_KEY  = 14;
  localparam int SRC_CONV = 15;

  localparam logic [1:0] ADR_EN   = 2'd0;
  localparam logic [1:0] ADR_REQ  = 2'd1;
  localparam logic [1:0] ADR_EDGE = 2'd2;
  localparam logic [1:0] ADR_CTRL = 2'd3;

  localparam logic [NUM_SRC-1:0] RST_REQ = {{(NUM_SRC-1){1'b0}}, 1'b1};

  // external pin k -> source index
  function automatic int pin_src(input int k);
    case (k)
      0:       return 1;
      1:       return 2;
      2:       return 9;
      3:       return 10;
      4:       return 12;
      5:       return 13;
      default: return 1;
    endcase
  endfunction

  // timer pulse bit j (2..6) -> source index
  function automatic int tmr_src(input int j);
    case (j)
      2:       return 5;
      3:       return 6;
      4:       return 7;
      5:       return 8;
      6:       return 11;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/irqc_edge_det.sv
module irqc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic act;
  logic act_q;

  // polarity applied before history: a polarity change can itself make an edge
  always_comb act = rise_sel_i ? lvl_i : ~lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b1;
    else        act_q <= act;
  end

  assign hit_o = act & ~act_q;
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N = 17,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] qual_i,
  output logic         any_o,
  output logic [W-1:0] win_o
);
  always_comb begin
    win_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (qual_i[i]) win_o = W'(i);
    end
    any_o = |qual_i;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int                NUM_PINS = 6,
  parameter int                KEY_W    = 8,
  parameter int                DATA_W   = 16,
  parameter int                VEC_W    = 16,
  parameter logic [VEC_W-1:0]  VEC_TOP  = 16'hFFFC,
  localparam int               SRC_W    = $clog2(NUM_SRC),
  localparam int               MSK_HI   = NUM_SRC - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] ext_pin_i,
  input  logic [KEY_W-1:0]    key_port_i,
  input  logic [KEY_W-1:0]    key_inmode_i,
  input  logic                adt_pin_i,
  input  logic [7:0]          evt_i,
  input  logic                brk_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  input  logic                ack_i,
  output logic                irq_o,
  output logic                push_o,
  output logic [SRC_W-1:0]    src_o,
  output logic [VEC_W-1:0]    vec_lo_o,
  output logic [VEC_W-1:0]    vec_hi_o,
  output logic                iflag_o
);
  logic rst_i_n;

  logic [NUM_PINS-1:0] pin_sync, pin_hit;
  logic [KEY_W-1:0]    key_sync;
  logic                adt_sync, key_hit, adt_hit, key_lvl;

  logic [MSK_HI:1]     en_q;
  logic [NUM_PINS-1:0] pol_q;
  logic                ser_q, adsel_q, iflag_q, iflag_d;
  logic [NUM_SRC-1:0]  req_q, req_d, set_v, clr_v, qual;
  logic                any, take;
  logic [SRC_W-1:0]    win;
  logic                en_we, pol_we, ctl_we, req_we;

  logic [SRC_W-1:0]    src_q;
  logic [VEC_W-1:0]    vlo_q, vhi_q, vlo_d, vhi_d;
  logic                push_q;

  irqc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  irqc_sync #(.W(NUM_PINS)) u_pin_sync (
    .clk(clk), .rst_n(rst_i_n), .async_i(ext_pin_i), .sync_o(pin_sync));
  irqc_sync #(.W(KEY_W)) u_key_sync (
    .clk(clk), .rst_n(rst_i_n), .async_i(key_port_i), .sync_o(key_sync));
  irqc_sync #(.W(1)) u_adt_sync (
    .clk(clk), .rst_n(rst_i_n), .async_i(adt_pin_i), .sync_o(adt_sync));

  for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
    irqc_edge_det u_det (
      .clk(clk), .rst_n(rst_i_n), .lvl_i(pin_sync[k]),
      .rise_sel_i(pol_q[k]), .hit_o(pin_hit[k]));
  end

  always_comb key_lvl = &(key_sync | ~key_inmode_i);

  irqc_edge_det u_key_det (
    .clk(clk), .rst_n(rst_i_n), .lvl_i(key_lvl), .rise_sel_i(1'b0), .hit_o(key_hit));
  irqc_edge_det u_adt_det (
    .clk(clk), .rst_n(rst_i_n), .lvl_i(adt_sync), .rise_sel_i(1'b0), .hit_o(adt_hit));

  // register port decode
  always_comb begin
    en_we  = reg_we_i && (reg_addr_i == ADR_EN);
    req_we = reg_we_i && (reg_addr_i == ADR_REQ);
    pol_we = reg_we_i && (reg_addr_i == ADR_EDGE);
    ctl_we = reg_we_i && (reg_addr_i == ADR_CTRL);
  end

  // request set sources
  always_comb begin
    set_v = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      set_v[pin_src(k)] = set_v[pin_src(k)] | pin_hit[k];
    end
    for (int j = 2; j <= 6; j++) begin
      set_v[tmr_src(j)] = evt_i[j];
    end
    set_v[SRC_RX]   = evt_i[0] & ser_q;
    set_v[SRC_TX]   = evt_i[1] & ser_q;
    set_v[SRC_KEY]  = key_hit;
    set_v[SRC_CONV] = adsel_q ? evt_i[7] : adt_hit;
    set_v[SRC_BRK]  = brk_i;
  end

  // qualification and selection
  always_comb begin
    qual    = '0;
    qual[0] = req_q[0];
    for (int i = 1; i <= MSK_HI; i++) begin
      qual[i] = req_q[i] & en_q[i] & ~iflag_q;
    end
    qual[SRC_BRK] = req_q[SRC_BRK];
  end

  irqc_prio #(.N(NUM_SRC)) u_prio (.qual_i(qual), .any_o(any), .win_o(win));

  always_comb begin
    irq_o = any & rst_i_n;
    take  = ack_i & irq_o;
  end

  // request next state: event set beats every clear
  always_comb begin
    clr_v = '0;
    if (req_we) begin
      for (int i = 1; i <= MSK_HI; i++) clr_v[i] = ~reg_wdata_i[i];
    end
    if (take) clr_v[win] = 1'b1;
    req_d = (req_q & ~clr_v) | set_v;
  end

  always_comb begin
    iflag_d = iflag_q;
    if (ctl_we) iflag_d = reg_wdata_i[2];
    if (take)   iflag_d = 1'b1;
    vlo_d = VEC_TOP - (VEC_W'(win) << 1);
    vhi_d = VEC_TOP + VEC_W'(1) - (VEC_W'(win) << 1);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      req_q   <= RST_REQ;
      iflag_q <= 1'b1;
      push_q  <= 1'b0;
    end else begin
      req_q   <= req_d;
      iflag_q <= iflag_d;
      push_q  <= take;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q    <= '0;
      pol_q   <= '0;
      ser_q   <= 1'b0;
      adsel_q <= 1'b0;
    end else begin
      if (en_we)  en_q  <= reg_wdata_i[MSK_HI:1];
      if (pol_we) pol_q <= reg_wdata_i[NUM_PINS-1:0];
      if (ctl_we) begin
        ser_q   <= reg_wdata_i[0];
        adsel_q <= reg_wdata_i[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      src_q <= '0;
      vlo_q <= '0;
      vhi_q <= '0;
    end else if (take) begin
      src_q <= win;
      vlo_q <= vlo_d;
      vhi_q <= vhi_d;
    end
  end

  assign push_o   = push_q;
  assign src_o    = src_q;
  assign vec_lo_o = vlo_q;
  assign vec_hi_o = vhi_q;
  assign iflag_o  = iflag_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int               VEC_W   = 16,
  parameter int               SRC_W   = 5,
  parameter logic [VEC_W-1:0] VEC_TOP = 16'hFFFC,
  parameter int               BRK_IDX = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             irq_o,
  input logic             push_o,
  input logic [SRC_W-1:0] src_o,
  input logic [VEC_W-1:0] vec_lo_o,
  input logic [VEC_W-1:0] vec_hi_o,
  input logic             iflag_o
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_q <= 1'b0;
    else if (push_o) seen_q <= 1'b1;
  end

  AST_PUSH_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> ($past(ack_i) && $past(irq_o))); // R5
  AST_ACK_GIVES_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ack_i) && $past(irq_o)) |-> push_o); // R5
  AST_FLAG_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> iflag_o); // R5
  AST_VEC_MATCHES_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> ((vec_lo_o == VEC_TOP - (VEC_W'(src_o) << 1)) && (vec_hi_o == vec_lo_o + VEC_W'(1)))); // R2
  AST_MASKED_ONLY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && $past(iflag_o)) |-> ((src_o == '0) || (src_o == SRC_W'(BRK_IDX)))); // R3
  AST_STARTUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && !seen_q) |-> (src_o == '0)); // R1
endmodule

bind irq_vector_ctrl irqc_checker #(
  .VEC_W(VEC_W), .SRC_W(SRC_W), .VEC_TOP(VEC_TOP), .BRK_IDX(irqc_pkg::SRC_BRK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .irq_o(irq_o), .push_o(push_o),
  .src_o(src_o), .vec_lo_o(vec_lo_o), .vec_hi_o(vec_hi_o), .iflag_o(iflag_o)
);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  ext_pin;
  logic [7:0]  key_port, key_inmode, evt;
  logic        adt_pin, brk, we, ack;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic        irq_o, push_o, iflag_o;
  logic [4:0]  src_o;
  logic [15:0] vec_lo_o, vec_hi_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .key_port_i(key_port),
    .key_inmode_i(key_inmode), .adt_pin_i(adt_pin), .evt_i(evt), .brk_i(brk),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .ack_i(ack),
    .irq_o(irq_o), .push_o(push_o), .src_o(src_o), .vec_lo_o(vec_lo_o),
    .vec_hi_o(vec_hi_o), .iflag_o(iflag_o));

  typedef struct packed {
    logic [15:0] en;
    logic [2:0]  ctrl;
    logic [7:0]  ev;
    logic        brk;
    logic        irq;
    logic [4:0]  src;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{16'hFFFE, 3'd0, 8'h50, 1'b0, 1'b1, 5'd7},   // R2 timer 2 beats timer 1
    '{16'hFFFE, 3'd0, 8'h28, 1'b0, 1'b1, 5'd6},   // R13 timer Y beats timer 3
    '{16'h0000, 3'd0, 8'h04, 1'b0, 1'b0, 5'd0},   // R3 enable off
    '{16'hFFFE, 3'd4, 8'h04, 1'b0, 1'b0, 5'd0},   // R3 flag set
    '{16'h0000, 3'd4, 8'h00, 1'b1, 1'b1, 5'd16},  // R4 break ignores masks
    '{16'hFFFE, 3'd0, 8'h40, 1'b1, 1'b1, 5'd11},  // R4 break loses to timer 1
    '{16'hFFDE, 3'd0, 8'h24, 1'b0, 1'b1, 5'd8},   // R3 disabled 5 skipped
    '{16'hFFFE, 3'd0, 8'h01, 1'b0, 1'b0, 5'd0},   // R11 serial off
    '{16'hFFFE, 3'd1, 8'h03, 1'b0, 1'b1, 5'd3},   // R11 receive first
    '{16'hFFFE, 3'd2, 8'h80, 1'b0, 1'b1, 5'd15},  // R10 done selected
    '{16'hFFFE, 3'd0, 8'h80, 1'b0, 1'b0, 5'd0},   // R10 done ignored
    '{16'hFFFE, 3'd1, 8'h02, 1'b0, 1'b1, 5'd4}    // R11 transmit
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e, input logic b);
    evt = e; brk = b;
    tick();
    evt = '0; brk = 1'b0;
  endtask

  task automatic take_chk(input int s, input string rq);
    logic [15:0] lo;
    lo = 16'hFFFC - 16'(2 * s);
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk(push_o == 1'b1, {rq, " push"}, 32'(push_o), 1);
    chk(src_o == 5'(s), {rq, " src"}, 32'(src_o), 32'(s));
    chk(vec_lo_o == lo, {rq, " vec_lo"}, 32'(vec_lo_o), 32'(lo));
    chk(vec_hi_o == lo + 16'd1, {rq, " vec_hi"}, 32'(vec_hi_o), 32'(lo + 16'd1));
    chk(iflag_o == 1'b1, {rq, " flag"}, 32'(iflag_o), 1);
  endtask

  task automatic drain;
    wr(2'd1, 16'h0000);
    wr(2'd3, 16'h0004);
    for (int n = 0; n < 4; n++) begin
      if (irq_o) begin
        ack = 1'b1;
        tick();
        ack = 1'b0;
      end
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_pin = '0; key_port = 8'hFF; key_inmode = 8'h0F;
    evt = '0; adt_pin = 1'b1; brk = 1'b0; we = 1'b0; ack = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_n(3);

    // R1 reset state and start-up request
    chk(iflag_o == 1'b1, "R1 flag", 32'(iflag_o), 1);
    chk(push_o == 1'b0, "R1 push", 32'(push_o), 0);
    chk(irq_o == 1'b1, "R1 pending", 32'(irq_o), 1);
    take_chk(0, "R1");
    chk(irq_o == 1'b0, "R1 nothing left", 32'(irq_o), 0);

    // vector table walk
    foreach (TBL[i]) begin
      drain();
      wr(2'd0, TBL[i].en);
      wr(2'd3, {13'd0, TBL[i].ctrl});
      pulse(TBL[i].ev, TBL[i].brk);
      chk(irq_o == TBL[i].irq, "R2 R3 R4 R10 R11 R13 table irq", 32'(irq_o), 32'(TBL[i].irq));
      if (TBL[i].irq) take_chk(int'(TBL[i].src), "R2 table");
    end

    // R6 writing 1 to requests sets nothing
    drain();
    wr(2'd0, 16'hFFFE);
    wr(2'd3, 16'h0000);
    wr(2'd1, 16'hFFFF);
    chk(irq_o == 1'b0, "R6 write-one inert", 32'(irq_o), 0);

    // R6 software clear
    pulse(8'h04, 1'b0);
    chk(irq_o == 1'b1, "R6 pending before clear", 32'(irq_o), 1);
    wr(2'd1, 16'hFFDF);
    chk(irq_o == 1'b0, "R6 cleared", 32'(irq_o), 0);

    // R12 event and clear in the same cycle
    evt = 8'h04; we = 1'b1; addr = 2'd1; wdata = 16'hFFDF;
    tick();
    evt = '0; we = 1'b0;
    chk(irq_o == 1'b1, "R12 set wins", 32'(irq_o), 1);
    take_chk(5, "R12");

    // R5 others stay latched, flag masks them after accept
    drain();
    wr(2'd0, 16'hFFFE);
    wr(2'd3, 16'h0000);
    pulse(8'h50, 1'b0);
    take_chk(7, "R5 first");
    chk(irq_o == 1'b0, "R5 masked after accept", 32'(irq_o), 0);
    wr(2'd3, 16'h0000);
    chk(irq_o == 1'b1, "R5 still latched", 32'(irq_o), 1);
    take_chk(11, "R5 second");

    // R5 acknowledge with nothing pending
    drain();
    ack = 1'b1;
    tick();
    ack = 1'b0;
    chk(push_o == 1'b0, "R5 idle ack", 32'(push_o), 0);

    // R7 pin0 rising, synchronizer latency
    wr(2'd0, 16'hFFFE);
    wr(2'd2, 16'h0001);
    wr(2'd3, 16'h0000);
    ext_pin[0] = 1'b1;
    wait_n(2);
    chk(irq_o == 1'b0, "R7 not yet", 32'(irq_o), 0);
    tick();
    chk(irq_o == 1'b1, "R7 third edge", 32'(irq_o), 1);
    take_chk(1, "R7 pin0");

    // R7 pin4 falling polarity
    wr(2'd3, 16'h0000);
    ext_pin[4] = 1'b1;
    wait_n(4);
    chk(irq_o == 1'b0, "R7 rise ignored", 32'(irq_o), 0);
    ext_pin[4] = 1'b0;
    wait_n(4);
    chk(irq_o == 1'b1, "R7 fall seen", 32'(irq_o), 1);
    take_chk(12, "R7 pin4");

    // R8 polarity change sets request
    ext_pin[2] = 1'b1;
    wait_n(4);
    wr(2'd3, 16'h0000);
    chk(irq_o == 1'b0, "R8 before change", 32'(irq_o), 0);
    wr(2'd2, 16'h0005);
    chk(irq_o == 1'b0, "R8 write cycle", 32'(irq_o), 0);
    tick();
    chk(irq_o == 1'b1, "R8 spurious set", 32'(irq_o), 1);
    take_chk(9, "R8");

    // R9 keypad AND over input-mode bits
    wr(2'd3, 16'h0000);
    key_port[6] = 1'b0;
    wait_n(4);
    chk(irq_o == 1'b0, "R9 output bit ignored", 32'(irq_o), 0);
    key_port[1] = 1'b0;
    wait_n(4);
    chk(irq_o == 1'b1, "R9 key fall", 32'(irq_o), 1);
    take_chk(14, "R9");

    // R10 trigger pin falling edge
    wr(2'd3, 16'h0000);
    adt_pin = 1'b0;
    wait_n(4);
    chk(irq_o == 1'b1, "R10 trigger pin", 32'(irq_o), 1);
    take_chk(15, "R10");

    summary();
    $finish;
  end
endmodule